// File: doc/BRIEF.md
# Odd-Parity Hamming ECC Memory Path

This block guards 7-bit data words on their way into and out of a memory array. On the write side it turns each data word into a 12-bit stored word. Four check bits are interleaved with the data to form an 11-bit Hamming codeword. One overall parity bit then sits on top as the most significant bit. Every parity group and the whole stored word use odd parity.

On the read side the block takes a 12-bit stored word and regenerates the four check bits from the received data positions. It XORs them with the received check bits to form a syndrome and compares the overall parity. A single flipped bit anywhere in the 12 bits is repaired, the check bits are dropped, and the 7 data bits come out with a syndrome and two status flags. The first flag marks a corrected single error. The second marks an uncorrectable error. Syndromes that point past the codeword are treated as uncorrectable.

The encode path and the decode path are combinational. A parameter adds one register stage with a valid strobe to each path, which gives one cycle of latency. Each registered stage loads only when its input valid is high.

Top module: `ecc7_path`

## Requirements
- R1: Codeword position p (1 to 11) is stored in bit p-1 of the 12-bit word. Data bits 6, 5 and 4 go to positions 11, 10 and 9. Data bits 3, 2 and 1 go to positions 7, 6 and 5. Data bit 0 goes to position 3.
- R2: Check bit k (k = 0..3) sits at position 2^k. It is set so that all positions whose index has bit k set, the check bit included, hold an odd number of ones.
- R3: Bit 11 of the stored word is set so that all 12 bits hold an odd number of ones. Data 1011010 encodes to 12'hDDB.
- R4: The read syndrome is the received check bits XOR the regenerated check bits, with check bit 0 as its LSB. For an unaltered stored word it is 0.
- R5: An unaltered stored word returns its data with both error flags low.
- R6: With a nonzero syndrome of 1 to 11 and wrong overall parity, the bit at that position is inverted before the data is extracted, the single-error flag is set, and the double-error flag stays low. The two flags are never high together.
- R7: If only bit 11 is flipped, the syndrome is 0 and the data passes unchanged with the single-error flag set.
- R8: A nonzero syndrome with correct overall parity, as caused by any two flipped bits, sets the double-error flag only. The data is then taken from the received positions without correction.
- R9: A syndrome of 12 to 15 sets the double-error flag and clears the single-error flag, whatever the overall parity. No bit is corrected.
- R10: With the register stage enabled, each output valid equals its input valid one cycle earlier. Results appear one cycle after the input, and the data outputs hold their value while the input valid is low.
- R11: During reset and just after it, both output valids, the stored word, the read data, the syndrome and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_in_valid | input | 1 | Write data present |
| wr_data | input | 7 | Data word to encode |
| wr_out_valid | output | 1 | Encoded word present |
| wr_word | output | 12 | Encoded word for the memory |
| rd_in_valid | input | 1 | Stored word present |
| rd_word | input | 12 | Word read back from the memory |
| rd_out_valid | output | 1 | Decode results present |
| rd_data | output | 7 | Corrected (or passed-through) data |
| rd_syndrome | output | 4 | Check-bit syndrome |
| rd_single_err | output | 1 | Single error found and corrected |
| rd_double_err | output | 1 | Uncorrectable error found |

## Verification
The bench flips every one of the 12 bits of stored words, including each check bit and the top parity bit. A decoder that mishandled check-bit positions or the top bit would then corrupt data that needed no repair, or it would raise the wrong flag. Every pair of flipped bits is also tried, which includes the pair that gives syndrome 12. Triple flips give syndromes 13 and 14 together with wrong parity. A design that trusted overall parity alone would "correct" a bit that does not exist, or it would flag a single error. The bench also checks the one-cycle alignment and the hold behaviour while valid is low, where a missing clock enable shows up as outputs that drift.

// File: rtl/ecc7_pkg.sv
package ecc7_pkg;

  localparam int ECC_DATA_W = 7;
  localparam int ECC_CHK_W  = 4;
  localparam int ECC_CW_W   = ECC_DATA_W + ECC_CHK_W;
  localparam int ECC_WORD_W = ECC_CW_W + 1;

  // Check bits live at power-of-two positions.
  function automatic logic is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // Codeword position (1-based) holding data bit idx: the idx-th
  // non-power-of-two position counted upward from 1.
  function automatic int data_pos(input int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p <= 2 * ECC_WORD_W; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  typedef struct packed {
    logic [ECC_DATA_W-1:0] data;
    logic [ECC_CHK_W-1:0]  syn;
    logic                  single_err;
    logic                  double_err;
  } ecc_rd_t;

endpackage

// File: rtl/ecc7_chkgen.sv
module ecc7_chkgen
  import ecc7_pkg::*;
#(
  parameter int DATA_W = ECC_DATA_W,
  parameter int CHK_W  = ECC_CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);

  // Each check bit closes its group to odd parity over the data it covers.
  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    logic acc_k;
    always_comb begin
      acc_k = 1'b1;
      for (int i = 0; i < DATA_W; i++) begin
        if (((data_pos(i) >> k) & 1) == 1) acc_k = acc_k ^ data_i[i];
      end
    end
    assign chk_o[k] = acc_k;
  end

endmodule

// File: rtl/ecc7_encoder.sv
module ecc7_encoder
  import ecc7_pkg::*;
#(
  parameter int DATA_W = ECC_DATA_W,
  parameter int CHK_W  = ECC_CHK_W,
  localparam int CW_W   = DATA_W + CHK_W,
  localparam int WORD_W = CW_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o
);

  logic [CHK_W-1:0] chk;
  logic [CW_W-1:0]  cw;

  ecc7_chkgen #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W)
  ) u_gen (
    .data_i (data_i),
    .chk_o  (chk)
  );

  always_comb begin
    cw = '0;
    for (int i = 0; i < DATA_W; i++) cw[data_pos(i)-1] = data_i[i];
    for (int k = 0; k < CHK_W; k++)  cw[(1 << k)-1]    = chk[k];
  end

  // Top bit makes the whole stored word odd.
  assign word_o = {~^cw, cw};

endmodule

// File: rtl/ecc7_decoder.sv
module ecc7_decoder
  import ecc7_pkg::*;
#(
  parameter int DATA_W = ECC_DATA_W,
  parameter int CHK_W  = ECC_CHK_W,
  localparam int CW_W   = DATA_W + CHK_W,
  localparam int WORD_W = CW_W + 1
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  syn_o,
  output logic              single_o,
  output logic              double_o
);

  logic [CW_W-1:0]   cw_rx;
  logic [DATA_W-1:0] data_rx;
  logic [CHK_W-1:0]  chk_rx;
  logic [CHK_W-1:0]  chk_gen;
  logic [CHK_W-1:0]  syn;
  logic              par_ok;
  logic              syn_nz;
  logic              syn_in_range;
  logic              do_fix;
  logic [CW_W-1:0]   flip_mask;
  logic [CW_W-1:0]   cw_fix;

  assign cw_rx = word_i[CW_W-1:0];

  always_comb begin
    for (int i = 0; i < DATA_W; i++) data_rx[i] = cw_rx[data_pos(i)-1];
    for (int k = 0; k < CHK_W; k++)  chk_rx[k]  = cw_rx[(1 << k)-1];
  end

  ecc7_chkgen #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W)
  ) u_regen (
    .data_i (data_rx),
    .chk_o  (chk_gen)
  );

  assign syn          = chk_rx ^ chk_gen;
  assign par_ok       = ^word_i;
  assign syn_nz       = |syn;
  assign syn_in_range = (syn <= CHK_W'(CW_W));
  assign do_fix       = syn_nz && syn_in_range && !par_ok;

  always_comb begin
    for (int p = 1; p <= CW_W; p++) flip_mask[p-1] = do_fix && (syn == CHK_W'(p));
  end

  assign cw_fix = cw_rx ^ flip_mask;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) data_o[i] = cw_fix[data_pos(i)-1];
  end

  assign syn_o    = syn;
  assign single_o = !par_ok && syn_in_range;
  assign double_o = !syn_in_range || (syn_nz && par_ok);

endmodule

// File: rtl/ecc7_outstage.sv
module ecc7_outstage #(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  if (OUT_REG) begin : g_reg
    logic         vld_q;
    logic [W-1:0] dat_q;
    logic [W-1:0] dat_nxt;

    always_comb begin
      dat_nxt = in_valid ? in_data : dat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else begin
        vld_q <= in_valid;
        dat_q <= dat_nxt;
      end
    end

    assign out_valid = vld_q;
    assign out_data  = dat_q;
  end else begin : g_pass
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end

endmodule

// File: rtl/ecc7_rst_sync.sv
module ecc7_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ecc7_path.sv
module ecc7_path
  import ecc7_pkg::*;
#(
  parameter bit OUT_REG     = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_in_valid,
  input  logic [ECC_DATA_W-1:0] wr_data,
  output logic                  wr_out_valid,
  output logic [ECC_WORD_W-1:0] wr_word,
  input  logic                  rd_in_valid,
  input  logic [ECC_WORD_W-1:0] rd_word,
  output logic                  rd_out_valid,
  output logic [ECC_DATA_W-1:0] rd_data,
  output logic [ECC_CHK_W-1:0]  rd_syndrome,
  output logic                  rd_single_err,
  output logic                  rd_double_err
);

  localparam int RD_W = $bits(ecc_rd_t);

  logic                  rst_int_n;
  logic [ECC_WORD_W-1:0] enc_word;
  ecc_rd_t               dec_res;
  ecc_rd_t               dec_out;
  logic [RD_W-1:0]       dec_out_bits;

  ecc7_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ecc7_encoder #(
    .DATA_W (ECC_DATA_W),
    .CHK_W  (ECC_CHK_W)
  ) u_enc (
    .data_i (wr_data),
    .word_o (enc_word)
  );

  ecc7_decoder #(
    .DATA_W (ECC_DATA_W),
    .CHK_W  (ECC_CHK_W)
  ) u_dec (
    .word_i   (rd_word),
    .data_o   (dec_res.data),
    .syn_o    (dec_res.syn),
    .single_o (dec_res.single_err),
    .double_o (dec_res.double_err)
  );

  ecc7_outstage #(
    .W       (ECC_WORD_W),
    .OUT_REG (OUT_REG)
  ) u_wr_stage (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (wr_in_valid),
    .in_data   (enc_word),
    .out_valid (wr_out_valid),
    .out_data  (wr_word)
  );

  ecc7_outstage #(
    .W       (RD_W),
    .OUT_REG (OUT_REG)
  ) u_rd_stage (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (rd_in_valid),
    .in_data   (dec_res),
    .out_valid (rd_out_valid),
    .out_data  (dec_out_bits)
  );

  assign dec_out       = ecc_rd_t'(dec_out_bits);
  assign rd_data       = dec_out.data;
  assign rd_syndrome   = dec_out.syn;
  assign rd_single_err = dec_out.single_err;
  assign rd_double_err = dec_out.double_err;

endmodule

// File: rtl/ecc7_path_chk.sv
module ecc7_path_chk
  import ecc7_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_in_valid,
  input logic                  wr_out_valid,
  input logic [ECC_WORD_W-1:0] wr_word,
  input logic                  rd_in_valid,
  input logic                  rd_out_valid,
  input logic [ECC_CHK_W-1:0]  rd_syndrome,
  input logic                  rd_single_err,
  input logic                  rd_double_err
);

  logic [ECC_CHK_W-1:0] grp_odd;

  always_comb begin
    for (int k = 0; k < ECC_CHK_W; k++) begin
      grp_odd[k] = 1'b0;
      for (int p = 1; p <= ECC_CW_W; p++) begin
        if (((p >> k) & 1) == 1) grp_odd[k] = grp_odd[k] ^ wr_word[p-1];
      end
    end
  end

  AST_ENC_GROUPS_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_valid |-> (&grp_odd)); // R2

  AST_ENC_WORD_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_valid |-> (^wr_word)); // R3

  AST_CLEAN_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out_valid && rd_syndrome == '0 && !rd_single_err) |-> !rd_double_err); // R5

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out_valid |-> !(rd_single_err && rd_double_err)); // R6

  AST_SINGLE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out_valid && rd_single_err) |-> (rd_syndrome <= ECC_CHK_W'(ECC_CW_W))); // R6

  AST_SYN_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out_valid && rd_syndrome > ECC_CHK_W'(ECC_CW_W)) |-> (rd_double_err && !rd_single_err)); // R9

  if (OUT_REG) begin : g_lat
    AST_WR_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_in_valid |=> wr_out_valid); // R10

    AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_in_valid |=> rd_out_valid); // R10

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_in_valid |=> $stable(wr_word)); // R10

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_in_valid |=> ($stable(rd_syndrome) && $stable(rd_single_err) && $stable(rd_double_err))); // R10
  end

endmodule

bind ecc7_path ecc7_path_chk #(
  .OUT_REG (OUT_REG)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_in_valid   (wr_in_valid),
  .wr_out_valid  (wr_out_valid),
  .wr_word       (wr_word),
  .rd_in_valid   (rd_in_valid),
  .rd_out_valid  (rd_out_valid),
  .rd_syndrome   (rd_syndrome),
  .rd_single_err (rd_single_err),
  .rd_double_err (rd_double_err)
);

// File: tb/ecc7_path_tb.sv
`timescale 1ns/1ps
module ecc7_path_tb;

  localparam int POS [7] = '{3, 5, 6, 7, 9, 10, 11};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_in_valid;
  logic [6:0]  wr_data;
  logic        wr_out_valid;
  logic [11:0] wr_word;
  logic        rd_in_valid;
  logic [11:0] rd_word;
  logic        rd_out_valid;
  logic [6:0]  rd_data;
  logic [3:0]  rd_syndrome;
  logic        rd_single_err;
  logic        rd_double_err;

  int checks = 0;
  int errors = 0;

  // Expected outputs after the current cycle's edge.
  logic [11:0] e_ww;
  logic        e_wov;
  logic [6:0]  e_rd;
  logic [3:0]  e_rs;
  logic        e_se;
  logic        e_de;
  logic        e_rov;

  always #2 clk = ~clk;

  ecc7_path u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_in_valid   (wr_in_valid),
    .wr_data       (wr_data),
    .wr_out_valid  (wr_out_valid),
    .wr_word       (wr_word),
    .rd_in_valid   (rd_in_valid),
    .rd_word       (rd_word),
    .rd_out_valid  (rd_out_valid),
    .rd_data       (rd_data),
    .rd_syndrome   (rd_syndrome),
    .rd_single_err (rd_single_err),
    .rd_double_err (rd_double_err)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference encoder: the XOR of the indices of all set positions must be 4'hF.
  function automatic logic [11:0] m_encode(input logic [6:0] d);
    logic [11:0] w;
    int x;
    int c;
    w = '0;
    x = 0;
    for (int i = 0; i < 7; i++) begin
      if (d[i]) begin
        w[POS[i]-1] = 1'b1;
        x = x ^ POS[i];
      end
    end
    c = x ^ 15;
    for (int k = 0; k < 4; k++) if (((c >> k) & 1) == 1) w[(1 << k)-1] = 1'b1;
    w[11] = ~^w[10:0];
    return w;
  endfunction

  task automatic m_decode(input logic [11:0] w, output logic [6:0] d, output logic [3:0] s,
                          output logic se, output logic de);
    int x;
    logic [11:0] c;
    logic ok;
    x = 0;
    for (int p = 1; p <= 11; p++) if (w[p-1]) x = x ^ p;
    s  = 4'(x ^ 15);
    ok = ^w;
    c  = w;
    se = 1'b0;
    de = 1'b0;
    if (s == 0) se = !ok;
    else if (s > 11) de = 1'b1;
    else if (!ok) begin
      se = 1'b1;
      c[s-1] = ~c[s-1];
    end else de = 1'b1;
    for (int i = 0; i < 7; i++) d[i] = c[POS[i]-1];
  endtask

  task automatic step(input logic wv, input logic [6:0] d, input logic rv, input logic [11:0] w,
                      input string wtag, input string rtag);
    @(negedge clk);
    wr_in_valid = wv;
    wr_data     = d;
    rd_in_valid = rv;
    rd_word     = w;
    if (wv) e_ww = m_encode(d);
    e_wov = wv;
    if (rv) m_decode(w, e_rd, e_rs, e_se, e_de);
    e_rov = rv;
    @(posedge clk);
    #1;
    chk(wtag, "wr_out_valid", int'(wr_out_valid), int'(e_wov));
    chk(wtag, "wr_word", int'(wr_word), int'(e_ww));
    if (wv) begin
      for (int k = 0; k < 4; k++) begin
        logic g;
        g = 1'b0;
        for (int p = 1; p <= 11; p++) if (((p >> k) & 1) == 1) g = g ^ wr_word[p-1];
        chk("R2", "group parity", int'(g), 1);
      end
      chk("R3", "word parity", int'(^wr_word), 1);
    end
    chk(rtag, "rd_out_valid", int'(rd_out_valid), int'(e_rov));
    chk(rtag, "rd_data", int'(rd_data), int'(e_rd));
    chk("R4", "rd_syndrome", int'(rd_syndrome), int'(e_rs));
    chk(rtag, "rd_single_err", int'(rd_single_err), int'(e_se));
    chk(rtag, "rd_double_err", int'(rd_double_err), int'(e_de));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [11:0] w;
    rst_n       = 1'b0;
    wr_in_valid = 1'b0;
    wr_data     = '0;
    rd_in_valid = 1'b0;
    rd_word     = '0;
    e_ww = '0; e_wov = 1'b0; e_rd = '0; e_rs = '0; e_se = 1'b0; e_de = 1'b0; e_rov = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R11: state while reset is held
    chk("R11", "wr_out_valid", int'(wr_out_valid), 0);
    chk("R11", "rd_out_valid", int'(rd_out_valid), 0);
    chk("R11", "wr_word", int'(wr_word), 0);
    chk("R11", "rd_flags", int'({rd_data, rd_syndrome, rd_single_err, rd_double_err}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b0, '0, "R11", "R11");

    // R3, R6: known example word and one flipped data bit at position 7
    step(1'b1, 7'b1011010, 1'b1, 12'hDDB ^ 12'h040, "R1", "R6");
    chk("R3", "example word", int'(wr_word), 'hDDB);
    chk("R6", "example syndrome", int'(rd_syndrome), 7);
    chk("R6", "example data", int'(rd_data), 'b1011010);
    chk("R6", "example flag", int'(rd_single_err), 1);

    // R1, R5: every data value, encoded and read back clean
    for (int d = 0; d < 128; d++) step(1'b1, 7'(d), 1'b1, m_encode(7'(d)), "R1", "R5");

    // R6, R7: every single-bit flip
    for (int s = 0; s < 16; s++) begin
      for (int b = 0; b < 12; b++) begin
        w = m_encode(7'((s * 9 + 5) % 128)) ^ (12'h1 << b);
        step(1'b1, 7'(s * 7), 1'b1, w, "R1", (b == 11) ? "R7" : "R6");
      end
    end
    step(1'b0, '0, 1'b1, m_encode(7'h2A) ^ 12'h800, "R10", "R7");
    chk("R7", "top-bit syndrome", int'(rd_syndrome), 0);
    chk("R7", "top-bit data", int'(rd_data), 'h2A);

    // R8: every pair of flipped bits
    for (int s = 0; s < 3; s++) begin
      for (int b1 = 0; b1 < 12; b1++) begin
        for (int b2 = b1 + 1; b2 < 12; b2++) begin
          w = m_encode(7'(s * 41 + 3)) ^ (12'h1 << b1) ^ (12'h1 << b2);
          step(1'b0, '0, 1'b1, w, "R10", "R8");
        end
      end
    end

    // R9: syndromes beyond position 11
    step(1'b0, '0, 1'b1, m_encode(7'h55) ^ 12'h089, "R10", "R9");
    chk("R9", "syndrome 13", int'(rd_syndrome), 13);
    chk("R9", "double flag", int'(rd_double_err), 1);
    chk("R9", "single flag", int'(rd_single_err), 0);
    step(1'b0, '0, 1'b1, m_encode(7'h33) ^ 12'h08A, "R10", "R9");
    chk("R9", "syndrome 14", int'(rd_syndrome), 14);
    step(1'b0, '0, 1'b1, m_encode(7'h0F) ^ 12'h088, "R10", "R9");
    chk("R9", "syndrome 12", int'(rd_syndrome), 12);
    step(1'b0, '0, 1'b1, m_encode(7'h70) ^ 12'h08F, "R10", "R9");

    // R10: outputs hold while valids are low and inputs change
    step(1'b1, 7'h19, 1'b1, m_encode(7'h19) ^ 12'h004, "R10", "R10");
    for (int i = 0; i < 6; i++) step(1'b0, 7'($urandom), 1'b0, 12'($urandom), "R10", "R10");

    // Mixed random traffic with random valids and error masks
    for (int i = 0; i < 600; i++) begin
      logic [6:0] d;
      logic [11:0] m;
      d = 7'($urandom);
      case ($urandom % 4)
        0: m = '0;
        1: m = 12'h1 << ($urandom % 12);
        2: m = (12'h1 << ($urandom % 12)) ^ (12'h1 << ($urandom % 12));
        default: m = 12'($urandom);
      endcase
      step(1'($urandom), 7'($urandom), 1'($urandom), m_encode(d) ^ m, "R10", "R8");
    end

    finish_run();
  end

endmodule